// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the digital half of a dual-modulus feedback path in a frequency synthesizer. It is clocked by the output of an external two-modulus prescaler. Each division cycle it counts a main ratio N of prescaler output periods. For the first A of those periods it holds the modulus-control line high, which makes the prescaler divide by P+1. For the remaining N−A periods the line is low and the prescaler divides by P. One division cycle therefore spans P×N+A prescaler input cycles. The block emits one comparison pulse per cycle for the phase detector.

The ratios N (11 bits) and A (7 bits) and a band-select bit arrive as plain control levels from the configuration latches. The block checks each request for legality. A legal request is captured into a shadow copy, and the running counters take that copy only at the next cycle boundary. An illegal request raises a flag and leaves the last legal setting in force. The band-select bit is carried to the prescaler through the same boundary register, on the `wide_o` line. While the enable is low the divider is idle, as it is in power-saving mode. All ports are plain control and status levels. No data stream crosses the block, so it has no valid/ready handshake and no back-pressure.

Top module: `swl_fb_div`

## Requirements
- R1: With a legal setting (N, A) the comparison pulse repeats every N clock cycles, so the prescaler input count per cycle is P×N+A.
- R2: Within each division cycle `mod_ctl_o` is high for exactly the first A clock cycles, as one unbroken run that starts at the first cycle after the boundary, and it is low in the cycle that carries the comparison pulse.
- R3: When A = 0, `mod_ctl_o` stays low for the whole division cycle.
- R4: `cmp_pulse_o` is high for exactly one clock cycle per division cycle.
- R5: A change to N or A applied in the middle of a cycle does not alter the length of that cycle. It takes effect from the following cycle.
- R6: A request with N < 3, or with A ≥ N, sets `bad_cfg_o` high from the clock edge after the request. The last legal N and A stay in use. `bad_cfg_o` returns low one edge after a legal request.
- R7: While `en_i` is low, `mod_ctl_o` and `cmp_pulse_o` are low from the next edge on. After `en_i` rises, the first edge loads the counters, and the first pulse appears N cycles after that edge.
- R8: `wide_o` is the inverse of `narrow_sel_i`: 1 selects the larger prescaler modulus pair. It changes only at a cycle boundary.
- R9: After reset, `mod_ctl_o`, `cmp_pulse_o` and `bad_cfg_o` are 0 and `wide_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Prescaler output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable, active high; low holds the divider idle |
| n_ratio_i | input | NW (11) | Requested main counter ratio N |
| a_ratio_i | input | AW (7) | Requested swallow count A |
| narrow_sel_i | input | 1 | 1 selects the smaller prescaler modulus pair |
| mod_ctl_o | output | 1 | Modulus control to prescaler, 1 = divide by P+1 |
| cmp_pulse_o | output | 1 | One-cycle comparison pulse per division cycle |
| wide_o | output | 1 | Boundary-registered modulus pair select to prescaler |
| bad_cfg_o | output | 1 | Last requested N/A was illegal |

## Verification
The bench covers these corner cases:
- The smallest legal ratio N = 3, which would break a counter that reloads late.
- A = N−1, which shows whether the swallow run spills into the pulse cycle or is cut one short.
- A = 0, where a design that counts the swallow counter through zero would raise modulus control.
- The largest N and A together.
- A ratio and a band change in the middle of a cycle, which a design without the boundary register would apply at once and so produce a short cycle.
- Illegal requests, which an unchecked design would load and so hang or mis-divide.
- A resume from idle, where an off-by-one start would move the first pulse.

// File: rtl/swl_fb_div_pkg.sv
package swl_fb_div_pkg;

  parameter int unsigned SFD_N_MIN = 3;

  // Legal when main ratio meets the floor and swallow count is below it.
  function automatic logic ratio_ok(int unsigned n, int unsigned a);
    return (n >= SFD_N_MIN) && (a < n);
  endfunction

endpackage

// File: rtl/swl_cfg_hold.sv
module swl_cfg_hold #(
  parameter int unsigned NW    = 11,
  parameter int unsigned AW    = 7,
  parameter int unsigned N_RST = 3,
  parameter int unsigned A_RST = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NW-1:0] n_req_i,
  input  logic [AW-1:0] a_req_i,
  input  logic          narrow_req_i,
  output logic [NW-1:0] n_shd_o,
  output logic [AW-1:0] a_shd_o,
  output logic          narrow_shd_o,
  output logic          bad_o
);

  logic req_ok;

  assign req_ok = swl_fb_div_pkg::ratio_ok(int'(n_req_i), int'(a_req_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_shd_o      <= NW'(N_RST);
      a_shd_o      <= AW'(A_RST);
      narrow_shd_o <= 1'b0;
      bad_o        <= 1'b0;
    end else begin
      bad_o        <= !req_ok;
      narrow_shd_o <= narrow_req_i;
      if (req_ok) begin
        n_shd_o <= n_req_i;
        a_shd_o <= a_req_i;
      end
    end
  end

endmodule

// File: rtl/swl_cycle_cnt.sv
module swl_cycle_cnt #(
  parameter int unsigned NW = 11,
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_shd_i,
  input  logic [AW-1:0] a_shd_i,
  input  logic          narrow_shd_i,
  output logic          mod_ctl_o,
  output logic          pulse_o,
  output logic          wide_o
);

  localparam logic [NW-1:0] MAIN_ONE = NW'(1);
  localparam logic [AW-1:0] SWL_ONE  = AW'(1);

  logic [NW-1:0] main_q;
  logic [AW-1:0] swl_q;
  logic          boundary;

  // Boundary: last count of a cycle, or idle state after enable.
  assign boundary = (main_q <= MAIN_ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= '0;
      swl_q  <= '0;
      wide_o <= 1'b1;
    end else if (!en_i) begin
      main_q <= '0;
      swl_q  <= '0;
    end else if (boundary) begin
      main_q <= n_shd_i;
      swl_q  <= a_shd_i;
      wide_o <= !narrow_shd_i;
    end else begin
      main_q <= main_q - MAIN_ONE;
      if (swl_q != '0) swl_q <= swl_q - SWL_ONE;
    end
  end

  assign mod_ctl_o = (swl_q != '0);
  assign pulse_o   = (main_q == MAIN_ONE);

endmodule

// File: rtl/swl_fb_div.sv
module swl_fb_div #(
  parameter int unsigned NW    = 11,
  parameter int unsigned AW    = 7,
  parameter int unsigned N_RST = 3,
  parameter int unsigned A_RST = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [NW-1:0] n_ratio_i,
  input  logic [AW-1:0] a_ratio_i,
  input  logic          narrow_sel_i,
  output logic          mod_ctl_o,
  output logic          cmp_pulse_o,
  output logic          wide_o,
  output logic          bad_cfg_o
);

  logic [NW-1:0] n_shd;
  logic [AW-1:0] a_shd;
  logic          narrow_shd;

  swl_cfg_hold #(.NW(NW), .AW(AW), .N_RST(N_RST), .A_RST(A_RST)) cfg_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .n_req_i      (n_ratio_i),
    .a_req_i      (a_ratio_i),
    .narrow_req_i (narrow_sel_i),
    .n_shd_o      (n_shd),
    .a_shd_o      (a_shd),
    .narrow_shd_o (narrow_shd),
    .bad_o        (bad_cfg_o)
  );

  swl_cycle_cnt #(.NW(NW), .AW(AW)) cnt_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .n_shd_i      (n_shd),
    .a_shd_i      (a_shd),
    .narrow_shd_i (narrow_shd),
    .mod_ctl_o    (mod_ctl_o),
    .pulse_o      (cmp_pulse_o),
    .wide_o       (wide_o)
  );

endmodule

// File: rtl/swl_fb_div_chk.sv
module swl_fb_div_chk #(
  parameter int unsigned NW = 11,
  parameter int unsigned AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic [NW-1:0] n_ratio_i,
  input logic [AW-1:0] a_ratio_i,
  input logic          mod_ctl_o,
  input logic          cmp_pulse_o,
  input logic          wide_o,
  input logic          bad_cfg_o
);

  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!mod_ctl_o && !cmp_pulse_o));

  p_pulse_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |=> !cmp_pulse_o);

  p_pulse_mod_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_pulse_o |-> !mod_ctl_o);

  p_bad_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((n_ratio_i < NW'(3)) || (NW'(a_ratio_i) >= n_ratio_i)) |=> bad_cfg_o);

  p_wide_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_ctl_o |=> $stable(wide_o));

endmodule

bind swl_fb_div swl_fb_div_chk #(.NW(NW), .AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .n_ratio_i   (n_ratio_i),
  .a_ratio_i   (a_ratio_i),
  .mod_ctl_o   (mod_ctl_o),
  .cmp_pulse_o (cmp_pulse_o),
  .wide_o      (wide_o),
  .bad_cfg_o   (bad_cfg_o)
);

// File: tb/swl_fb_div_tb_top.sv
module swl_fb_div_tb_top;

  localparam int HIGH_BAND = 1;
  // Row: {N[18:8], A[7:1], narrow[0]}
  localparam logic [18:0] VEC [8] = '{
    {11'd3,    7'd0,   1'b1},
    {11'd3,    7'd2,   1'b0},
    {11'd4,    7'd1,   1'b1},
    {11'd17,   7'd5,   1'b0},
    {11'd100,  7'd99,  1'b1},
    {11'd64,   7'd0,   1'b0},
    {11'd12,   7'd11,  1'b1},
    {11'd2047, 7'd127, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [10:0] n_r = 11'd3;
  logic [6:0]  a_r = 7'd0;
  logic        nar = 1'b0;
  logic        mod_ctl, pulse, wide, bad;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  swl_fb_div dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .n_ratio_i(n_r), .a_ratio_i(a_r), .narrow_sel_i(nar),
    .mod_ctl_o(mod_ctl), .cmp_pulse_o(pulse), .wide_o(wide), .bad_cfg_o(bad)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!pulse);
  endtask

  // Starts at a pulse sample; ends at the next pulse sample.
  task automatic measure(output int len, output int hi, output bit contig, output bit wide_s);
    len = 0; hi = 0; contig = 1'b1; wide_s = 1'b0;
    do begin
      @(negedge clk);
      len++;
      if (mod_ctl) begin
        hi++;
        if (len != hi) contig = 1'b0;
      end
      wide_s = wide;
    end while (!pulse && len < 5000);
  endtask

  initial begin
    int len, hi, pcnt, k;
    bit contig, ws, quiet;

    repeat (3) @(negedge clk);
    check(!mod_ctl && !pulse && !bad && wide, "R9 reset state",
          {mod_ctl, pulse, bad, wide}, 4'b0001);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;

    // Table walk
    for (int i = 0; i < 8; i++) begin
      int vn, va, p;
      bit vr;
      vn = int'(VEC[i][18:8]);
      va = int'(VEC[i][7:1]);
      vr = VEC[i][0];
      n_r = VEC[i][18:8]; a_r = VEC[i][7:1]; nar = vr;
      p = vr ? (HIGH_BAND ? 64 : 32) : (HIGH_BAND ? 128 : 64);
      wait_pulse();
      measure(len, hi, contig, ws);
      measure(len, hi, contig, ws);
      check(len == vn, "R1 cycle length N", len, vn);
      check(len * p + hi == vn * p + va, "R1 total P*N+A", len * p + hi, vn * p + va);
      if (va == 0) check(hi == 0, "R3 no swallow when A=0", hi, 0);
      else         check(hi == va, "R2 swallow run length", hi, va);
      check(contig, "R2 swallow run leads cycle", int'(contig), 1);
      check(ws == !vr, "R8 wide select", int'(ws), int'(!vr));
    end

    // R4 single pulse width
    n_r = 11'd5; a_r = 7'd2; nar = 1'b0;
    wait_pulse();
    @(negedge clk);
    check(!pulse, "R4 pulse one cycle wide", int'(pulse), 0);

    // R5 mid-cycle ratio change
    n_r = 11'd40; a_r = 7'd3;
    wait_pulse();
    measure(len, hi, contig, ws);
    k = 0;
    repeat (10) begin @(negedge clk); k++; end
    n_r = 11'd7; a_r = 7'd1;
    while (!pulse && k < 5000) begin @(negedge clk); k++; end
    check(k == 40, "R5 running cycle keeps old N", k, 40);
    measure(len, hi, contig, ws);
    check(len == 7, "R5 new N next cycle", len, 7);
    check(hi == 1, "R5 new A next cycle", hi, 1);

    // R6 illegal requests
    n_r = 11'd6; a_r = 7'd1;
    wait_pulse();
    measure(len, hi, contig, ws);
    n_r = 11'd2;
    @(negedge clk);
    check(bad, "R6 flag on N<3", int'(bad), 1);
    wait_pulse();
    measure(len, hi, contig, ws);
    check(len == 6 && hi == 1, "R6 keeps legal N after N<3", len, 6);
    n_r = 11'd9; a_r = 7'd9;
    @(negedge clk);
    check(bad, "R6 flag on A>=N", int'(bad), 1);
    wait_pulse();
    measure(len, hi, contig, ws);
    check(len == 6 && hi == 1, "R6 keeps legal A after A>=N", len * 1000 + hi, 6001);
    a_r = 7'd8;
    @(negedge clk);
    check(!bad, "R6 flag clears on legal", int'(bad), 0);
    wait_pulse();
    measure(len, hi, contig, ws);
    measure(len, hi, contig, ws);
    check(len == 9 && hi == 8, "R6 legal value applied", len * 1000 + hi, 9008);

    // R8 band change mid-cycle
    n_r = 11'd30; a_r = 7'd4; nar = 1'b1;
    wait_pulse();
    measure(len, hi, contig, ws);
    measure(len, hi, contig, ws);
    repeat (5) @(negedge clk);
    nar = 1'b0;
    quiet = 1'b1;
    while (!pulse) begin @(negedge clk); if (wide) quiet = 1'b0; end
    check(quiet, "R8 wide held until boundary", int'(quiet), 1);
    @(negedge clk);
    check(wide, "R8 wide updates at boundary", int'(wide), 1);

    // R7 idle and resume
    n_r = 11'd5; a_r = 7'd2;
    en = 1'b0;
    @(negedge clk);
    quiet = 1'b1;
    repeat (20) begin @(negedge clk); if (mod_ctl || pulse) quiet = 1'b0; end
    check(quiet, "R7 idle outputs low", int'(quiet), 1);
    en = 1'b1;
    k = 0; pcnt = 0;
    do begin @(negedge clk); k++; if (mod_ctl) pcnt++; end while (!pulse && k < 100);
    check(k == 5, "R7 first pulse after resume", k, 5);
    check(pcnt == 2, "R7 swallow run after resume", pcnt, 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule